// File: doc/BRIEF.md
# PHY Status Register Bank

This block is a small bank of control-side registers for a USB transceiver. The host reaches it through a simple synchronous register port. The port carries an address, a read strobe, a write strobe and write data. Read data is combinational from the address.

The bank holds three registers:

- **Event latch.** Five status inputs are watched for edges. Each input has its own rising-enable and falling-enable mask bit. A qualified edge sets a sticky bit. Reading the register returns the bits and empties it.
- **Debug view.** A read-only view of the live two-bit line state.
- **Scratch byte.** Free for software. It can be replaced, bit-set or bit-cleared by writing to three different addresses.

The status inputs must already be synchronous to the register clock. A source in another clock domain needs a two-flop synchronizer in front of the block. An edge is judged against the input's value on the previous clock. That previous value tracks the input while reset is held, so a level present when reset is released never counts as an edge.

Top module: `phy_stat_regs`

## Requirements
- R1: After reset the event latch (address 14h) and the scratch byte (address 16h) both read 00h.
- R2: Event latch layout at address 14h: bit 4 = ID ground, bit 3 = session end, bit 2 = session valid, bit 1 = VBUS valid, bit 0 = host disconnect. These are `stat_in[4:0]` in the same positions. Bits 7..5 always read 0.
- R3: When `stat_in[i]` is 1 and was 0 on the previous cycle, and `rise_en[i]` is 1, latch bit i is set at the next clock edge.
- R4: When `stat_in[i]` is 0 and was 1 on the previous cycle, and `fall_en[i]` is 1, latch bit i is set at the next clock edge.
- R5: An edge whose enable bit is 0 leaves the latch unchanged.
- R6: A read strobe at 14h returns the current latch value and clears every bit at the end of that cycle.
- R7: An event in the same cycle as a latch read does not appear in that read. Its bit is set afterwards.
- R8: Latch bits stay set across later cycles and further events until the latch is read.
- R9: Address 15h reads `{6'b0, line_state}` live. Writes to 15h have no effect.
- R10: A write to 16h replaces the scratch byte. Reads at 16h, 17h and 18h all return the scratch byte.
- R11: A write to 17h sets the scratch bits that are 1 in the write data.
- R12: A write to 18h clears the scratch bits that are 1 in the write data.
- R13: Reads of any address other than 14h to 18h return 00h. Writes to 14h, 15h or unmapped addresses change neither the latch nor the scratch byte.
- R14: A status level present when reset is released does not set a latch bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Register clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_addr | input | 8 | Register address |
| reg_rd | input | 1 | Read strobe; a read at 14h clears the latch |
| reg_wr | input | 1 | Write strobe |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for `reg_addr` (combinational) |
| stat_in | input | 5 | Synchronous status inputs, bit order as in R2 |
| rise_en | input | 5 | Per-input rising-edge enable |
| fall_en | input | 5 | Per-input falling-edge enable |
| line_state | input | 2 | Live line state shown at 15h |

## Verification
The bench drives an event in the same cycle as a latch read. A design that gave the clear priority would lose that event, and a design that merged the event would return it early. Masked edges and both edge polarities are exercised, so swapped enables or level-sensitive detection show up as spurious or missing bits. A status level is held high through reset. This catches a previous-value register that resets to 0 instead of tracking the input. Scratch set and clear use overlapping patterns, and writes to read-only and unmapped addresses are checked afterwards. A wrong alias decode or a write leaking into the latch shows up as a corrupted byte.

// File: rtl/phy_stat_pkg.sv
package phy_stat_pkg;

    localparam int unsigned DATA_W  = 8;
    localparam int unsigned ADDR_W  = 8;
    localparam int unsigned N_STAT  = 5;
    localparam int unsigned LS_W    = 2;

    localparam logic [ADDR_W-1:0] ADR_EVT     = 8'h14;
    localparam logic [ADDR_W-1:0] ADR_DBG     = 8'h15;
    localparam logic [ADDR_W-1:0] ADR_SCR_LD  = 8'h16;
    localparam logic [ADDR_W-1:0] ADR_SCR_SET = 8'h17;
    localparam logic [ADDR_W-1:0] ADR_SCR_CLR = 8'h18;

    typedef enum logic [1:0] {
        RSEL_NONE,
        RSEL_EVT,
        RSEL_DBG,
        RSEL_SCR
    } rsel_e;

    typedef enum logic [1:0] {
        SOP_HOLD,
        SOP_LOAD,
        SOP_SET,
        SOP_CLR
    } sop_e;

    typedef struct packed {
        rsel_e rsel;
        sop_e  sop;
        logic  evt_clr;
    } dec_t;

    function automatic dec_t decode(input logic [ADDR_W-1:0] a,
                                    input logic rd, input logic wr);
        dec_t d;
        d.rsel    = RSEL_NONE;
        d.sop     = SOP_HOLD;
        d.evt_clr = 1'b0;
        unique case (a)
            ADR_EVT: begin
                d.rsel    = RSEL_EVT;
                d.evt_clr = rd;
            end
            ADR_DBG: d.rsel = RSEL_DBG;
            ADR_SCR_LD: begin
                d.rsel = RSEL_SCR;
                if (wr) d.sop = SOP_LOAD;
            end
            ADR_SCR_SET: begin
                d.rsel = RSEL_SCR;
                if (wr) d.sop = SOP_SET;
            end
            ADR_SCR_CLR: begin
                d.rsel = RSEL_SCR;
                if (wr) d.sop = SOP_CLR;
            end
            default: ;
        endcase
        return d;
    endfunction

endpackage

// File: rtl/stat_edge_qual.sv
module stat_edge_qual #(
    parameter int unsigned N = 5
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] stat_in,
    input  logic [N-1:0] rise_en,
    input  logic [N-1:0] fall_en,
    output logic [N-1:0] evt
);
    logic [N-1:0] prev_q;

    // Tracks the input during reset so a level present at release is not an edge.
    always_ff @(posedge clk) begin
        prev_q <= stat_in;
    end

    for (genvar i = 0; i < N; i++) begin : g_bit
        logic rise_w, fall_w;
        assign rise_w = stat_in[i] & ~prev_q[i];
        assign fall_w = ~stat_in[i] & prev_q[i];
        assign evt[i] = ~rst & ((rise_w & rise_en[i]) | (fall_w & fall_en[i]));
    end
endmodule

// File: rtl/evt_latch.sv
module evt_latch #(
    parameter int unsigned N = 5
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] evt,
    input  logic         clr,
    output logic [N-1:0] q
);
    always_ff @(posedge clk) begin
        if (rst)
            q <= '0;
        else if (clr)
            q <= evt;          // concurrent events survive the clear
        else
            q <= q | evt;
    end
endmodule

// File: rtl/scratch_byte.sv
module scratch_byte
    import phy_stat_pkg::*;
#(
    parameter int unsigned W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  sop_e         op,
    input  logic [W-1:0] wdata,
    output logic [W-1:0] q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            q <= '0;
        end else begin
            unique case (op)
                SOP_LOAD: q <= wdata;
                SOP_SET:  q <= q | wdata;
                SOP_CLR:  q <= q & ~wdata;
                default:  q <= q;
            endcase
        end
    end
endmodule

// File: rtl/phy_stat_regs.sv
module phy_stat_regs
    import phy_stat_pkg::*;
#(
    parameter int unsigned DW = DATA_W,
    parameter int unsigned AW = ADDR_W,
    parameter int unsigned N  = N_STAT,
    parameter int unsigned LW = LS_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [AW-1:0] reg_addr,
    input  logic          reg_rd,
    input  logic          reg_wr,
    input  logic [DW-1:0] reg_wdata,
    output logic [DW-1:0] reg_rdata,
    input  logic [N-1:0]  stat_in,
    input  logic [N-1:0]  rise_en,
    input  logic [N-1:0]  fall_en,
    input  logic [LW-1:0] line_state
);
    localparam int unsigned EVT_PAD = DW - N;
    localparam int unsigned DBG_PAD = DW - LW;

    dec_t          dec;
    logic [N-1:0]  evt;
    logic [N-1:0]  latch_q;
    logic [DW-1:0] scr_q;

    assign dec = decode(reg_addr, reg_rd, reg_wr);

    stat_edge_qual #(.N(N)) i_qual (
        .clk     (clk),
        .rst     (rst),
        .stat_in (stat_in),
        .rise_en (rise_en),
        .fall_en (fall_en),
        .evt     (evt)
    );

    evt_latch #(.N(N)) i_latch (
        .clk (clk),
        .rst (rst),
        .evt (evt),
        .clr (dec.evt_clr),
        .q   (latch_q)
    );

    scratch_byte #(.W(DW)) i_scr (
        .clk   (clk),
        .rst   (rst),
        .op    (dec.sop),
        .wdata (reg_wdata),
        .q     (scr_q)
    );

    always_comb begin
        unique case (dec.rsel)
            RSEL_EVT: reg_rdata = {{EVT_PAD{1'b0}}, latch_q};
            RSEL_DBG: reg_rdata = {{DBG_PAD{1'b0}}, line_state};
            RSEL_SCR: reg_rdata = scr_q;
            default:  reg_rdata = '0;
        endcase
    end
endmodule

// File: rtl/phy_stat_regs_chk.sv
module phy_stat_regs_chk #(
    parameter int unsigned DW = 8,
    parameter int unsigned AW = 8,
    parameter int unsigned N  = 5,
    parameter int unsigned LW = 2
) (
    input logic          clk,
    input logic          rst,
    input logic [AW-1:0] reg_addr,
    input logic          reg_rd,
    input logic          reg_wr,
    input logic [DW-1:0] reg_wdata,
    input logic [DW-1:0] reg_rdata,
    input logic [LW-1:0] line_state,
    input logic [N-1:0]  evt,
    input logic [N-1:0]  latch_q,
    input logic [DW-1:0] scr_q
);
    logic evt_rd;
    logic in_map;
    assign evt_rd = reg_rd && reg_addr == AW'(8'h14);
    assign in_map = reg_addr >= AW'(8'h14) && reg_addr <= AW'(8'h18);

    // R6
    rd_clear_chk: assert property (@(posedge clk) disable iff (rst)
        evt_rd |=> latch_q == $past(evt));

    // R8
    sticky_chk: assert property (@(posedge clk) disable iff (rst)
        !evt_rd |=> (latch_q & $past(latch_q)) == $past(latch_q));

    // R3
    evt_set_chk: assert property (@(posedge clk) disable iff (rst)
        (|evt) |=> (latch_q & $past(evt)) == $past(evt));

    // R2
    resv_zero_chk: assert property (@(posedge clk) disable iff (rst)
        reg_addr == AW'(8'h14) |-> reg_rdata[DW-1:N] == '0);

    // R9
    dbg_view_chk: assert property (@(posedge clk) disable iff (rst)
        reg_addr == AW'(8'h15) |-> reg_rdata == DW'(line_state));

    // R13
    unmapped_chk: assert property (@(posedge clk) disable iff (rst)
        !in_map |-> reg_rdata == '0);

    // R11
    scr_set_chk: assert property (@(posedge clk) disable iff (rst)
        (reg_wr && reg_addr == AW'(8'h17)) |=> scr_q == ($past(scr_q) | $past(reg_wdata)));

    // R12
    scr_clr_chk: assert property (@(posedge clk) disable iff (rst)
        (reg_wr && reg_addr == AW'(8'h18)) |=> scr_q == ($past(scr_q) & ~$past(reg_wdata)));

    // R10
    scr_load_chk: assert property (@(posedge clk) disable iff (rst)
        (reg_wr && reg_addr == AW'(8'h16)) |=> scr_q == $past(reg_wdata));
endmodule

bind phy_stat_regs phy_stat_regs_chk #(.DW(DW), .AW(AW), .N(N), .LW(LW)) i_chk (
    .clk        (clk),
    .rst        (rst),
    .reg_addr   (reg_addr),
    .reg_rd     (reg_rd),
    .reg_wr     (reg_wr),
    .reg_wdata  (reg_wdata),
    .reg_rdata  (reg_rdata),
    .line_state (line_state),
    .evt        (evt),
    .latch_q    (latch_q),
    .scr_q      (scr_q)
);

// File: tb/test_phy_stat_regs.sv
module test_phy_stat_regs;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 5000;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [7:0] reg_addr = '0;
    logic       reg_rd = 1'b0;
    logic       reg_wr = 1'b0;
    logic [7:0] reg_wdata = '0;
    logic [7:0] reg_rdata;
    logic [4:0] stat_in = '0;
    logic [4:0] rise_en = '0;
    logic [4:0] fall_en = '0;
    logic [1:0] line_state = '0;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    typedef struct {
        logic [7:0] addr;
        logic [7:0] exp;
        string      tag;
    } sb_item_t;

    sb_item_t sb_q[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    phy_stat_regs i_phy_stat_regs (
        .clk        (clk),
        .rst        (rst),
        .reg_addr   (reg_addr),
        .reg_rd     (reg_rd),
        .reg_wr     (reg_wr),
        .reg_wdata  (reg_wdata),
        .reg_rdata  (reg_rdata),
        .stat_in    (stat_in),
        .rise_en    (rise_en),
        .fall_en    (fall_en),
        .line_state (line_state)
    );

    // Tasks are entered just after a falling edge and return at the next one.
    task automatic rd(input logic [7:0] a, input logic [7:0] exp, input string tag);
        sb_item_t it;
        it.addr = a; it.exp = exp; it.tag = tag;
        sb_q.push_back(it);
        reg_addr = a;
        reg_rd   = 1'b1;
        @(negedge clk);
        reg_rd   = 1'b0;
    endtask

    task automatic wr(input logic [7:0] a, input logic [7:0] d);
        reg_addr  = a;
        reg_wdata = d;
        reg_wr    = 1'b1;
        @(negedge clk);
        reg_wr    = 1'b0;
    endtask

    task automatic step(input logic [4:0] s);
        stat_in = s;
        @(negedge clk);
    endtask

    // Monitor: samples a quarter period after the falling edge.
    initial begin
        forever begin
            @(negedge clk);
            #(CLK_PERIOD/4);
            if (reg_rd) begin
                if (sb_q.size() == 0) begin
                    errors++;
                    $display("FAIL scoreboard: read with no expected item, actual %02h", reg_rdata);
                end else begin
                    sb_item_t it;
                    it = sb_q.pop_front();
                    checks++;
                    if (reg_rdata !== it.exp) begin
                        errors++;
                        $display("FAIL %s: addr %02h actual %02h expected %02h",
                                 it.tag, it.addr, reg_rdata, it.exp);
                    end
                end
            end
        end
    end

    initial begin
        for (int i = 0; i < WATCHDOG; i++) begin
            @(posedge clk);
            if (done) break;
        end
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        rise_en = 5'h1F;
        stat_in = 5'b00101;              // R14: level held through reset
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        rd(8'h14, 8'h00, "R1/R14 latch after reset");
        rd(8'h16, 8'h00, "R1 scratch after reset");

        // R3 rising edge on bit 4; R6 clear on read
        step(5'b10101);
        rd(8'h14, 8'h10, "R3 rise bit4");
        rd(8'h14, 8'h00, "R6 cleared by read");

        // R5 masked edges
        step(5'b00101);                  // fall bit4, fall_en=0
        rise_en = 5'b11101;
        step(5'b00111);                  // rise bit1, masked
        rd(8'h14, 8'h00, "R5 masked edges");

        // R4 falling edge on bit 0
        fall_en = 5'b00001;
        step(5'b00110);
        rd(8'h14, 8'h01, "R4 fall bit0");

        // R8 sticky across cycles and later events
        rise_en = 5'h1F;
        step(5'b01110);
        step(5'b01110);
        step(5'b01110);
        step(5'b01111);
        rd(8'h14, 8'h09, "R8 sticky bits");
        rd(8'h14, 8'h00, "R6 cleared again");

        // R2 every bit, reserved bits zero
        fall_en = 5'h1F;
        step(5'b10000);
        rd(8'h14, 8'h1F, "R2 all five bits");

        // R7 event coinciding with read
        step(5'b10010);
        stat_in = 5'b10110;
        rd(8'h14, 8'h02, "R7 read returns old value");
        rd(8'h14, 8'h04, "R7 concurrent event kept");

        // R13 writes to read-only and unmapped addresses
        step(5'b10111);                  // bit0 rise
        wr(8'h14, 8'hFF);
        wr(8'h15, 8'hFF);
        wr(8'h20, 8'hFF);
        rd(8'h14, 8'h01, "R13 latch unaffected by writes");
        rd(8'h16, 8'h00, "R13 scratch unaffected by writes");

        // R9 debug view
        line_state = 2'b10;
        rd(8'h15, 8'h02, "R9 line state 10");
        line_state = 2'b01;
        rd(8'h15, 8'h01, "R9 line state 01");

        // R13 unmapped reads
        rd(8'h13, 8'h00, "R13 unmapped 13h");
        rd(8'h19, 8'h00, "R13 unmapped 19h");
        rd(8'h00, 8'h00, "R13 unmapped 00h");

        // R10 / R11 / R12 scratch aliases
        wr(8'h16, 8'hA5);
        rd(8'h16, 8'hA5, "R10 load");
        rd(8'h17, 8'hA5, "R10 read via 17h");
        rd(8'h18, 8'hA5, "R10 read via 18h");
        wr(8'h17, 8'h0F);
        rd(8'h16, 8'hAF, "R11 set");
        wr(8'h18, 8'h81);
        rd(8'h16, 8'h2E, "R12 clear");
        wr(8'h16, 8'h3C);
        rd(8'h16, 8'h3C, "R10 reload");
        rd(8'h14, 8'h00, "R13 scratch does not touch latch");

        @(negedge clk);
        @(negedge clk);
        if (sb_q.size() != 0) begin
            errors++;
            $display("FAIL scoreboard: %0d items left, expected 0", sb_q.size());
        end
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule